// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block holds the control and status word of a single descriptor DMA channel, together with its command pointer. Software updates the channel through a 32-bit write port. A write to the control register is a masked update. The upper 16 bits select which status bits may change, and the lower 16 bits give their new values. After this merge the block applies a fixed set of rules. Wake and run make the channel active. Run revives a dead channel. Pause takes priority over both. A falling run bit stops the channel and can trigger a flush.

The command engine sees the status word directly. It is told to start fetching by a one-cycle scheduling pulse. It is told to drain buffered data by a one-cycle flush request. When the engine hits a fatal error it raises `kill`, which marks the channel dead and raises a one-cycle interrupt. The command pointer can only be written while the channel is both stopped and inactive, and it is always stored 16-byte aligned.

Top module: `dma_chan_csr`

## Requirements
- R1: After a synchronous active-low reset, the status word and command pointer are 0, and `sched_pulse`, `flush_req` and `irq` are 0.
- R2: A control write (`wr_sel` = 0) changes only run (bit 15), pause (bit 14), flush (bit 13), wake (bit 12) and device status (bits 7..0). Each of these changes only where the matching mask bit `wr_data[16+i]` is 1. Bits 11..8 are never written by software, and bits 9 and 8 stay 0.
- R3: After the merge, a set wake bit forces active (bit 10) to 1.
- R4: After the merge, a set run bit forces active to 1 and clears dead (bit 11).
- R5: A set pause bit clears active, and this rule overrides the wake and run rules.
- R6: When a control write takes run from 1 to 0, active and dead are cleared. If flush is then set, a flush request is issued and the flush bit is cleared.
- R7: In the cycle after a control write, `sched_pulse` is 1 exactly when active is set in the resulting status. `flush_req` is 1 when R6 fired or flush remains set. Both pulses last one cycle and are 0 in every other cycle.
- R8: `rd_data` is combinational from `rd_sel`. Select 0 (control) and select 3 read as 0. Select 1 reads the zero-extended status word. Select 2 reads the command pointer.
- R9: A pointer write (`wr_sel` = 2) is ignored while run or active is set. An accepted write stores `wr_data` with bits 3..0 forced to 0.
- R10: `kill` sets dead, clears active and pulses `irq` for one cycle on the next edge. It acts after any same-cycle control write and suppresses that write's scheduling pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status (ignored), 2 command pointer |
| wr_data | input | REG_W | Write data; for control, mask in [31:16] and value in [15:0] |
| rd_sel | input | 2 | Read target, encoded as in R8 |
| rd_data | output | REG_W | Read data |
| kill | input | 1 | Fatal error from the command engine |
| status_o | output | 16 | Current status word |
| sched_pulse | output | 1 | One-cycle request to start command processing |
| flush_req | output | 1 | One-cycle request to flush channel data |
| irq | output | 1 | One-cycle channel interrupt on kill |

## Verification
The bench targets five corner cases.

- **Pause written together with run or wake.** A design that applies the rules in the wrong order leaves the channel active.
- **Run cleared while flush is set.** A wrong design either keeps the flush bit or never pulses `flush_req`.
- **Writes to bits 11..8 with full mask.** A wrong design could resurrect or kill the channel from software.
- **Pointer writes with run or active set.** A wrong design lets the engine's pointer move mid-chain.
- **Kill arriving with a run write in the same cycle.** A wrong design leaves the channel active or scheduled.

Random masked writes, reads and kills are compared against a bench model of the status rules after every cycle.

// File: rtl/dcsr_pkg.sv
// Package: shared bit positions, write mask and register selects for the
// DMA channel control/status block. Assumes a 16-bit status word.
package dcsr_pkg;
    localparam int ST_W     = 16;
    localparam int DEV_W    = 8;
    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACT    = 10;
    localparam int B_BRTAKE = 8;

    // Status bits software may change through the control register.
    localparam logic [ST_W-1:0] SW_WRITABLE =
        (ST_W'(1) << B_RUN) | (ST_W'(1) << B_PAUSE) |
        (ST_W'(1) << B_FLUSH) | (ST_W'(1) << B_WAKE) |
        ST_W'((1 << DEV_W) - 1);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CPTR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dcsr_merge.sv
// Module: dcsr_merge
// Combinational next-status computation for a masked control write.
// Assumes mask and value are each one status word wide. The outputs are
// meaningful only when the caller actually performs a control write.
module dcsr_merge
    import dcsr_pkg::*;
(
    input  logic [ST_W-1:0] cur_st,
    input  logic [ST_W-1:0] wr_mask,
    input  logic [ST_W-1:0] wr_val,
    output logic [ST_W-1:0] nxt_st,
    output logic            want_sched,
    output logic            want_flush
);
    logic [ST_W-1:0] upd;

    // Merge the writable bits, then apply wake/run/pause and run-fall rules.
    always_comb begin
        upd        = wr_mask & SW_WRITABLE;
        nxt_st     = (cur_st & ~upd) | (wr_val & upd);
        want_flush = 1'b0;
        if (nxt_st[B_WAKE]) nxt_st[B_ACT] = 1'b1;
        if (nxt_st[B_RUN]) begin
            nxt_st[B_ACT]  = 1'b1;
            nxt_st[B_DEAD] = 1'b0;
        end
        if (nxt_st[B_PAUSE]) nxt_st[B_ACT] = 1'b0;
        if (cur_st[B_RUN] && !nxt_st[B_RUN]) begin
            nxt_st[B_ACT]  = 1'b0;
            nxt_st[B_DEAD] = 1'b0;
            if (nxt_st[B_FLUSH]) begin
                want_flush      = 1'b1;
                nxt_st[B_FLUSH] = 1'b0;
            end
        end
        want_sched = nxt_st[B_ACT];
        if (nxt_st[B_FLUSH]) want_flush = 1'b1;
    end
endmodule

// File: rtl/dcsr_cmdptr.sv
// Module: dcsr_cmdptr
// Command pointer register. Writes are dropped while locked. Accepted
// values are aligned by clearing the low ALIGN_BITS bits.
module dcsr_cmdptr #(
    parameter int REG_W      = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             locked,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ptr
);
    localparam logic [REG_W-1:0] ALIGN_MASK = ~REG_W'((1 << ALIGN_BITS) - 1);

    // Hold the pointer; load an aligned value only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (wr_en && !locked) ptr <= wr_data & ALIGN_MASK;
    end

    a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked) |=> $stable(ptr));
endmodule

// File: rtl/dma_chan_csr.sv
// Module: dma_chan_csr
// Control/status register block for one DMA channel: masked control
// writes, command pointer guard, kill handling and request pulses.
// Assumes REG_W is twice the status width (mask half, value half).
module dma_chan_csr
    import dcsr_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             kill,
    output logic [ST_W-1:0]  status_o,
    output logic             sched_pulse,
    output logic             flush_req,
    output logic             irq
);
    localparam int MASK_LSB = REG_W - ST_W;

    logic [ST_W-1:0]  status_q, merged, st_wr, st_d;
    logic             m_sched, m_flush, ctrl_wr, ptr_wr;
    logic [REG_W-1:0] cptr;

    assign ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    assign ptr_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_CPTR);

    dcsr_merge u_merge (
        .cur_st     (status_q),
        .wr_mask    (wr_data[MASK_LSB +: ST_W]),
        .wr_val     (wr_data[ST_W-1:0]),
        .nxt_st     (merged),
        .want_sched (m_sched),
        .want_flush (m_flush)
    );

    dcsr_cmdptr #(.REG_W(REG_W), .ALIGN_BITS(ALIGN_BITS)) u_cptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ptr_wr),
        .locked  (status_q[B_RUN] | status_q[B_ACT]),
        .wr_data (wr_data),
        .ptr     (cptr)
    );

    // Choose the post-write status, then let a kill override it.
    always_comb begin
        st_wr = ctrl_wr ? merged : status_q;
        st_d  = st_wr;
        if (kill) begin
            st_d[B_DEAD] = 1'b1;
            st_d[B_ACT]  = 1'b0;
        end
    end

    // Register the status word and the single-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q    <= '0;
            sched_pulse <= 1'b0;
            flush_req   <= 1'b0;
            irq         <= 1'b0;
        end else begin
            status_q    <= st_d;
            sched_pulse <= ctrl_wr && m_sched && !kill;
            flush_req   <= ctrl_wr && m_flush;
            irq         <= kill;
        end
    end

    // Read mux; the control register always reads as zero.
    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_STAT: rd_data = REG_W'(status_q);
            SEL_CPTR: rd_data = cptr;
            default:  rd_data = '0;
        endcase
    end

    assign status_o = status_q;

    a_r4_run_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !kill && wr_data[MASK_LSB+B_RUN] && wr_data[B_RUN] &&
         (wr_data[MASK_LSB+B_PAUSE] ? !wr_data[B_PAUSE] : !status_q[B_PAUSE]))
        |=> (status_o[B_ACT] && !status_o[B_DEAD]));

    a_r5_pause_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[MASK_LSB+B_PAUSE] && wr_data[B_PAUSE])
        |=> !status_o[B_ACT]);

    a_r6_run_fall_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && status_q[B_RUN] && wr_data[MASK_LSB+B_RUN] && !wr_data[B_RUN])
        |=> (!status_o[B_ACT] && !status_o[B_FLUSH]));

    a_r7_sched_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        sched_pulse |-> ($past(ctrl_wr) && status_o[B_ACT]));

    a_r10_kill_effect: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (status_o[B_DEAD] && !status_o[B_ACT] && irq && !sched_pulse));
endmodule

// File: tb/dma_chan_csr_test.sv
`timescale 1ns/1ps
module dma_chan_csr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        kill = 1'b0;
    logic [15:0] status_o;
    logic        sched_pulse, flush_req, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] e_st = '0;
    logic [31:0] e_ptr = '0;
    logic        e_sched = 0, e_flush = 0, e_irq = 0;

    always #2.5 clk = ~clk;

    dma_chan_csr uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .kill(kill),
        .status_o(status_o), .sched_pulse(sched_pulse), .flush_req(flush_req),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Requirement model of a control write: {flush, sched, new status}.
    function automatic logic [17:0] ref_ctrl(input logic [15:0] old, input logic [31:0] d);
        logic [15:0] m, v, s;
        logic fl;
        m  = d[31:16] & 16'hF0FF;
        v  = d[15:0];
        s  = (old & ~m) | (v & m);
        fl = 0;
        if (s[12]) s[10] = 1;
        if (s[15]) begin s[10] = 1; s[11] = 0; end
        if (s[14]) s[10] = 0;
        if (old[15] && !s[15]) begin
            s[10] = 0; s[11] = 0;
            if (s[13]) begin fl = 1; s[13] = 0; end
        end
        if (s[13]) fl = 1;
        return {fl, s[10], s};
    endfunction

    function automatic logic [31:0] ref_read(input logic [1:0] sel);
        case (sel)
            2'd1:    return {16'h0, e_st};
            2'd2:    return e_ptr;
            default: return 32'h0;
        endcase
    endfunction

    // One cycle of stimulus; update model, then check at the falling edge.
    task automatic do_op(input logic we, input logic [1:0] ws, input logic [31:0] d,
                         input logic kl, input logic [1:0] rs, input string tag);
        logic [17:0] r;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = d; kill = kl; rd_sel = rs;
        e_sched = 0; e_flush = 0; e_irq = kl;
        if (we && ws == 2'd0) begin
            r = ref_ctrl(e_st, d);
            e_st = r[15:0]; e_sched = r[16] & ~kl; e_flush = r[17];
        end else if (we && ws == 2'd2 && !(e_st[15] || e_st[10])) begin
            e_ptr = d & 32'hFFFF_FFF0;
        end
        if (kl) begin e_st[11] = 1; e_st[10] = 0; end
        @(negedge clk);
        wr_en = 0; kill = 0;
        chk({tag, " status"}, {16'h0, status_o}, {16'h0, e_st});
        chk("R7 sched_pulse", {31'h0, sched_pulse}, {31'h0, e_sched});
        chk("R7 flush_req", {31'h0, flush_req}, {31'h0, e_flush});
        chk("R10 irq", {31'h0, irq}, {31'h0, e_irq});
        chk("R8 rd_data", rd_data, ref_read(rs));
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", {16'h0, status_o}, 32'h0);
        chk("R1 pulses", {29'h0, sched_pulse, flush_req, irq}, 32'h0);
        rd_sel = 2'd2; #1;
        chk("R1 cmdptr", rd_data, 32'h0);

        do_op(1, 2'd2, 32'h1234_567F, 0, 2'd2, "R9 aligned ptr");
        do_op(1, 2'd0, 32'hFFFF_0000 | 32'h0F00, 0, 2'd1, "R2 locked bits");
        do_op(1, 2'd0, 32'h8000_8000, 0, 2'd0, "R4 run");
        chk("R8 ctrl read zero", rd_data, 32'h0);
        do_op(1, 2'd2, 32'hABCD_0000, 0, 2'd2, "R9 blocked ptr");
        do_op(1, 2'd0, 32'h2000_2000, 0, 2'd1, "R7 flush kept");
        do_op(1, 2'd0, 32'h8000_0000, 0, 2'd1, "R6 run fall flush");
        do_op(1, 2'd0, 32'h1000_1000, 0, 2'd1, "R3 wake");
        do_op(1, 2'd0, 32'hD000_D000, 0, 2'd1, "R5 pause over run");
        do_op(1, 2'd0, 32'h4000_0000, 0, 2'd1, "R5 unpause");
        do_op(0, 2'd0, 32'h0, 1, 2'd1, "R10 kill");
        do_op(1, 2'd0, 32'h8000_8000, 0, 2'd1, "R4 revive dead");
        do_op(1, 2'd0, 32'h8000_8000, 1, 2'd1, "R10 kill beats run");
        do_op(1, 2'd0, 32'h00FF_005A, 0, 2'd1, "R2 devstat");
        do_op(1, 2'd1, 32'hFFFF_FFFF, 0, 2'd3, "R2 status sel ignored");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            logic [1:0]  ws;
            d  = $urandom;
            ws = ($urandom % 4 == 0) ? 2'd2 : 2'd0;
            if ($urandom % 3 == 0) d[31:16] = d[31:16] & 16'h8000;
            do_op(($urandom % 8) != 0, ws, d, ($urandom % 16) == 0,
                  2'($urandom % 4), "R2 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule